// File: doc/BRIEF.md
# Six-Channel Multi-Format Serial Audio Receiver

This block takes six channels of PCM audio from three serial data lines that share one bit clock and one frame clock. Each data line carries two channels, called A and B, one in each half of the frame. A 3-bit format code chooses how a sample sits inside its half-frame. It can be left-justified, I2S (the MSB arrives one bit clock late), or right-justified with 16, 18, 20 or 24 significant bits. Every sample is returned as a sign-extended 24-bit word, and all six words of a frame appear together with a one-cycle valid strobe.

The whole block runs on the master clock `clk`. The bit clock either comes in on `sclk_in` and is edge-detected in the `clk` domain, or it is made inside the block by dividing `clk` by 2 or 4. In the second case it is driven out on `bclk_out` so the sender can time its data from it. Changing the format or the clock source throws away the frame in progress, and decoding starts again cleanly at the next frame-clock change.

Top module: `sarx_receiver`

## Requirements
- R1: Each of the three data lines carries two channels. In format codes 0 and 2 to 7 the A channel is the half-frame with `lrck_in` low and B is the half with it high. In code 1 (I2S) this is reversed, so A is the half with `lrck_in` high.
- R2: Code 0 (left-justified) takes the bit sampled at the first rising bit-clock edge after an `lrck_in` change as bit 23. The following bits fill bits 22 downward. Bits beyond the 24th are ignored, and a half-frame shorter than 24 bits leaves the unfilled low bits zero.
- R3: Code 1 (I2S) ignores the bit at the first rising edge of a half-frame and takes the bit at the second rising edge as bit 23. Otherwise it fills bits as in R2, so a half-frame of S bits yields min(S-1, 24) significant upper bits.
- R4: Codes 2, 3, 4 and 5 are right-justified with 16, 24, 20 and 18 bits respectively. The sample's LSB is the bit at the last rising edge before the `lrck_in` change, earlier padding bits are ignored, and the result is sign-extended to 24 bits.
- R5: Codes 6 and 7 decode exactly as code 0.
- R6: `samp_valid` pulses for one `clk` cycle, one cycle after the rising bit-clock edge at which `lrck_in` ends a B half-frame, and only if the A half-frame immediately before it was decoded. All six outputs change only together with that pulse and hold their values otherwise.
- R7: With `div_en` = 0, data and `lrck_in` are sampled in the `clk` cycle where `sclk_in` is first seen high after being low. Each `sclk_in` level must last at least one `clk` cycle.
- R8: With `div_en` = 1, the bit clock is `clk`/2 when `div_quarter` = 0 and `clk`/4 when `div_quarter` = 1. It is driven on `bclk_out`, and data is sampled at the `clk` edge where `bclk_out` rises. `sclk_in` is ignored in this mode. `bclk_out` is low while `div_en` = 0.
- R9: A change of `fmt_sel`, `div_en` or `div_quarter` discards the half-frame in progress and any held A samples. No valid pulse results until a complete A-then-B pair has been received under the new setting.
- R10: After reset `samp_valid` is 0, every sample output is 0 and `bclk_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fmt_sel | input | 3 | Framing format code |
| div_en | input | 1 | Use the internal divided bit clock |
| div_quarter | input | 1 | Divide by 4 instead of 2 |
| sclk_in | input | 1 | External bit clock |
| lrck_in | input | 1 | Frame clock |
| sdata_in | input | 3 | Serial data, one bit per line |
| bclk_out | output | 1 | Internally generated bit clock |
| samp_a | output | 3x24 | A-channel samples, one per line |
| samp_b | output | 3x24 | B-channel samples, one per line |
| samp_valid | output | 1 | One-cycle frame strobe |

## Verification
The bench surrounds every sample with padding bits set to one. A right-justified decoder that keeps a padding bit, or a left-justified or I2S decoder that keeps a bit past the 24th, would therefore return wrong upper or lower bits. Half-frames of 16 bits check zero-fill for left-justified and I2S and the exact-fit 16-bit right-justified case. An I2S decoder that is off by one bit clock would shift every word. Extreme values such as 0x800000 and 0x008000 expose missing or misplaced sign extension. A format change in the middle of a frame checks that no mixed frame is emitted, which a design without the discard rule would produce as an extra valid pulse. Runs in both divided modes, with random toggling on `sclk_in`, catch a wrong divide ratio or an external clock leaking into the divided path.

// File: rtl/sarx_pkg.sv
`timescale 1ns/1ps
package sarx_pkg;

    localparam int SAMPLE_W = 24;

    typedef enum logic [2:0] {
        FMT_LEFT  = 3'd0,
        FMT_I2S   = 3'd1,
        FMT_RJ16  = 3'd2,
        FMT_RJ24  = 3'd3,
        FMT_RJ20  = 3'd4,
        FMT_RJ18  = 3'd5,
        FMT_ALT6  = 3'd6,
        FMT_ALT7  = 3'd7
    } fmt_e;

    function automatic logic fmt_is_i2s(logic [2:0] f);
        return f == FMT_I2S;
    endfunction

    function automatic logic fmt_is_left(logic [2:0] f);
        return (f == FMT_LEFT) || (f == FMT_ALT6) || (f == FMT_ALT7);
    endfunction

endpackage

// File: rtl/sarx_bitclk.sv
`timescale 1ns/1ps
module sarx_bitclk #(
    parameter int POS_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sclk_in,
    input  logic             lrck_in,
    input  logic             div_en,
    input  logic             div_quarter,
    output logic             bclk_out,
    output logic             bit_tick,
    output logic             frame_edge,
    output logic             lrck_prev,
    output logic [POS_W-1:0] bit_pos
);
    localparam logic [POS_W-1:0] POS_MAX = {POS_W{1'b1}};

    typedef struct packed {
        logic [1:0]       cnt;
        logic             sclk;
        logic             lrck;
        logic [POS_W-1:0] pos;
    } bclk_st_t;

    bclk_st_t st_q, st_d;
    logic ext_tick, div_tick;
    logic [POS_W-1:0] pos_inc;

    always_comb begin
        ext_tick   = sclk_in & ~st_q.sclk;
        div_tick   = div_quarter ? (st_q.cnt == 2'd1) : ~st_q.cnt[0];
        bit_tick   = div_en ? div_tick : ext_tick;
        frame_edge = bit_tick && (lrck_in != st_q.lrck);
        pos_inc    = (st_q.pos == POS_MAX) ? POS_MAX : st_q.pos + 1'b1;
        bit_pos    = frame_edge ? '0 : pos_inc;
        lrck_prev  = st_q.lrck;
        bclk_out   = div_en ? (div_quarter ? st_q.cnt[1] : st_q.cnt[0]) : 1'b0;

        st_d      = st_q;
        st_d.sclk = sclk_in;
        st_d.cnt  = div_en ? st_q.cnt + 2'd1 : 2'd0;
        if (bit_tick) begin
            st_d.lrck = lrck_in;
            st_d.pos  = bit_pos;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R7: sample points never fall on consecutive cycles while the source is steady
    p_tick_isolated_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick ##1 ($stable(div_en) && $stable(div_quarter)) |-> !bit_tick);

    // R8: in divided mode the output clock rises right after each sample point
    p_rise_after_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (div_en && bit_tick) ##1 (div_en && $stable(div_quarter)) |-> $rose(bclk_out));

endmodule

// File: rtl/sarx_lane.sv
`timescale 1ns/1ps
module sarx_lane
    import sarx_pkg::*;
#(
    parameter int POS_W = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bit_tick,
    input  logic                frame_edge,
    input  logic [POS_W-1:0]    bit_pos,
    input  logic [2:0]          fmt,
    input  logic                sdata,
    output logic [SAMPLE_W-1:0] word
);
    localparam int IDX_W = $clog2(SAMPLE_W);

    typedef struct packed {
        logic [SAMPLE_W-1:0] shreg;
        logic [SAMPLE_W-1:0] cap;
    } lane_st_t;

    lane_st_t st_q, st_d;
    logic [POS_W-1:0] off;
    logic [POS_W-1:0] rel;
    logic [IDX_W-1:0] idx;

    // word of the half-frame that ends at the current edge
    always_comb begin
        case (fmt_e'(fmt))
            FMT_RJ16: word = {{(SAMPLE_W-16){st_q.shreg[15]}}, st_q.shreg[15:0]};
            FMT_RJ18: word = {{(SAMPLE_W-18){st_q.shreg[17]}}, st_q.shreg[17:0]};
            FMT_RJ20: word = {{(SAMPLE_W-20){st_q.shreg[19]}}, st_q.shreg[19:0]};
            FMT_RJ24: word = st_q.shreg;
            default:  word = st_q.cap;
        endcase
    end

    always_comb begin
        off  = fmt_is_i2s(fmt) ? POS_W'(1) : '0;
        rel  = bit_pos - off;
        idx  = IDX_W'(SAMPLE_W - 1) - rel[IDX_W-1:0];
        st_d = st_q;
        if (bit_tick) begin
            st_d.shreg = {st_q.shreg[SAMPLE_W-2:0], sdata};
            if (frame_edge) st_d.cap = '0;
            if ((bit_pos >= off) && (rel < POS_W'(SAMPLE_W))) st_d.cap[idx] = sdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R2: left-justified MSB is the bit taken at the frame-clock change
    p_left_msb_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_tick && frame_edge && fmt_is_left(fmt)) |=> (st_q.cap[SAMPLE_W-1] == $past(sdata)));

    // R3: I2S ignores the bit at the frame-clock change
    p_i2s_skip_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_tick && frame_edge && fmt_is_i2s(fmt)) |=> (st_q.cap == '0));

endmodule

// File: rtl/sarx_frame.sv
`timescale 1ns/1ps
module sarx_frame
    import sarx_pkg::*;
#(
    parameter int NUM_LINES = 3,
    parameter int CFG_W     = 5
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                frame_edge,
    input  logic                                lrck_prev,
    input  logic [2:0]                          fmt,
    input  logic [CFG_W-1:0]                    cfg,
    input  logic [NUM_LINES-1:0][SAMPLE_W-1:0]  words,
    output logic [NUM_LINES-1:0][SAMPLE_W-1:0]  out_a,
    output logic [NUM_LINES-1:0][SAMPLE_W-1:0]  out_b,
    output logic                                out_valid
);
    typedef struct packed {
        logic [CFG_W-1:0]                   cfg;
        logic                               phase_ok;
        logic                               a_seen;
        logic [NUM_LINES-1:0][SAMPLE_W-1:0] a_hold;
        logic [NUM_LINES-1:0][SAMPLE_W-1:0] a_out;
        logic [NUM_LINES-1:0][SAMPLE_W-1:0] b_out;
        logic                               valid;
    } frm_st_t;

    frm_st_t st_q, st_d;
    logic cfg_change;
    logic chan_b;

    always_comb begin
        cfg_change = (cfg != st_q.cfg);
        chan_b     = fmt_is_i2s(fmt) ? ~lrck_prev : lrck_prev;

        st_d       = st_q;
        st_d.valid = 1'b0;
        st_d.cfg   = cfg;
        if (cfg_change) begin
            st_d.phase_ok = 1'b0;
            st_d.a_seen   = 1'b0;
        end else if (frame_edge) begin
            if (st_q.phase_ok) begin
                if (!chan_b) begin
                    st_d.a_hold = words;
                    st_d.a_seen = 1'b1;
                end else begin
                    if (st_q.a_seen) begin
                        st_d.a_out = st_q.a_hold;
                        st_d.b_out = words;
                        st_d.valid = 1'b1;
                    end
                    st_d.a_seen = 1'b0;
                end
            end
            st_d.phase_ok = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_a     = st_q.a_out;
    assign out_b     = st_q.b_out;
    assign out_valid = st_q.valid;

    // R6: the strobe never lasts two cycles
    p_single_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    // R6: samples only move together with the strobe
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> ($stable(out_a) && $stable(out_b)));

    // R9: a setting change never yields a frame on the next cycle
    p_cfg_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_change |=> !out_valid);

endmodule

// File: rtl/sarx_receiver.sv
`timescale 1ns/1ps
module sarx_receiver
    import sarx_pkg::*;
#(
    parameter int NUM_LINES = 3,
    parameter int POS_W     = 6
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [2:0]                          fmt_sel,
    input  logic                                div_en,
    input  logic                                div_quarter,
    input  logic                                sclk_in,
    input  logic                                lrck_in,
    input  logic [NUM_LINES-1:0]                sdata_in,
    output logic                                bclk_out,
    output logic [NUM_LINES-1:0][SAMPLE_W-1:0]  samp_a,
    output logic [NUM_LINES-1:0][SAMPLE_W-1:0]  samp_b,
    output logic                                samp_valid
);
    localparam int CFG_W = 5;

    logic             bit_tick;
    logic             frame_edge;
    logic             lrck_prev;
    logic [POS_W-1:0] bit_pos;
    logic [NUM_LINES-1:0][SAMPLE_W-1:0] words;
    logic [CFG_W-1:0] cfg;

    assign cfg = {fmt_sel, div_en, div_quarter};

    sarx_bitclk #(.POS_W(POS_W)) u_bitclk (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclk_in    (sclk_in),
        .lrck_in    (lrck_in),
        .div_en     (div_en),
        .div_quarter(div_quarter),
        .bclk_out   (bclk_out),
        .bit_tick   (bit_tick),
        .frame_edge (frame_edge),
        .lrck_prev  (lrck_prev),
        .bit_pos    (bit_pos)
    );

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_lane
        sarx_lane #(.POS_W(POS_W)) u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .bit_tick  (bit_tick),
            .frame_edge(frame_edge),
            .bit_pos   (bit_pos),
            .fmt       (fmt_sel),
            .sdata     (sdata_in[g]),
            .word      (words[g])
        );
    end

    sarx_frame #(.NUM_LINES(NUM_LINES), .CFG_W(CFG_W)) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_edge(frame_edge),
        .lrck_prev (lrck_prev),
        .fmt       (fmt_sel),
        .cfg       (cfg),
        .words     (words),
        .out_a     (samp_a),
        .out_b     (samp_b),
        .out_valid (samp_valid)
    );

endmodule

// File: tb/sarx_receiver_bench.sv
`timescale 1ns/1ps
module sarx_receiver_bench;
    localparam int LINES = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic [2:0]       fmt_sel = 3'd0;
    logic             div_en = 1'b0;
    logic             div_quarter = 1'b0;
    logic             sclk_ext = 1'b0;
    logic             sclk_junk = 1'b0;
    logic             sclk_in;
    logic             lrck = 1'b0;
    logic [LINES-1:0] sd = '0;
    logic             bclk_out;
    logic [LINES-1:0][23:0] samp_a, samp_b;
    logic             samp_valid;

    assign sclk_in = div_en ? sclk_junk : sclk_ext;

    sarx_receiver u_sarx_receiver (
        .clk(clk), .rst_n(rst_n), .fmt_sel(fmt_sel), .div_en(div_en),
        .div_quarter(div_quarter), .sclk_in(sclk_in), .lrck_in(lrck),
        .sdata_in(sd), .bclk_out(bclk_out), .samp_a(samp_a),
        .samp_b(samp_b), .samp_valid(samp_valid)
    );

    typedef struct packed {
        logic [LINES-1:0][23:0] a;
        logic [LINES-1:0][23:0] b;
    } frame_t;

    frame_t expq[$];
    string  tagq[$];
    int n_checks = 0, n_err = 0, n_valid = 0, n_pushed = 0;
    bit done = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [23:0] act, input logic [23:0] exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    always @(negedge clk) sclk_junk <= 1'($urandom);

    function automatic int rjw(input logic [2:0] f);
        case (f)
            3'd2: return 16;
            3'd3: return 24;
            3'd4: return 20;
            3'd5: return 18;
            default: return 0;
        endcase
    endfunction

    function automatic logic stream_bit(input logic [2:0] f, input int s, input int p,
                                        input logic [23:0] v);
        int n;
        n = rjw(f);
        if (f == 3'd1) return (p >= 1 && p <= 24) ? v[24-p] : 1'b1;
        if (n != 0)    return (p >= s - n) ? v[n-1-(p-(s-n))] : 1'b1;
        return (p < 24) ? v[23-p] : 1'b1;
    endfunction

    function automatic logic [23:0] exp_word(input logic [2:0] f, input int s,
                                             input logic [23:0] v);
        int n, k;
        logic [23:0] full, m;
        n = rjw(f);
        full = 24'hFFFFFF;
        if (n != 0) begin
            m = full >> (24 - n);
            return v[n-1] ? (v | ~m) : (v & m);
        end
        k = (f == 3'd1) ? s - 1 : s;
        if (k > 24) k = 24;
        m = ~(full >> k);
        return v & m;
    endfunction

    function automatic logic [23:0] sample_val(input int k, input int idx);
        logic [31:0] h;
        if (k == 0) begin
            case (idx)
                0: return 24'h800000;
                1: return 24'h7FFFFF;
                2: return 24'h008000;
                3: return 24'hFF7FFF;
                4: return 24'h123456;
                default: return 24'hFFFFFF;
            endcase
        end
        h = (k * 6 + idx + 1) * 32'h9E3779B1;
        return h[31:8];
    endfunction

    task automatic drive_bit(input logic lr, input logic [LINES-1:0] bits);
        if (!div_en) begin
            @(negedge clk);
            sclk_ext = 1'b0; lrck = lr; sd = bits;
            repeat (2) @(negedge clk);
            sclk_ext = 1'b1;
            repeat (2) @(negedge clk);
        end else begin
            @(negedge bclk_out);
            @(negedge clk);
            lrck = lr; sd = bits;
        end
    endtask

    task automatic send_half(input logic lr, input logic [2:0] f, input int s,
                             input logic [LINES-1:0][23:0] vals);
        for (int p = 0; p < s; p++) begin
            logic [LINES-1:0] bits;
            for (int l = 0; l < LINES; l++) bits[l] = stream_bit(f, s, p, vals[l]);
            drive_bit(lr, bits);
        end
    endtask

    task automatic send_frame(input logic [2:0] f, input int s, input int k,
                              input string tag, input bit push, input bit only_a);
        frame_t e;
        logic [LINES-1:0][23:0] va, vb;
        logic alr;
        for (int l = 0; l < LINES; l++) begin
            va[l] = sample_val(k, 2 * l);
            vb[l] = sample_val(k, 2 * l + 1);
            e.a[l] = exp_word(f, s, va[l]);
            e.b[l] = exp_word(f, s, vb[l]);
        end
        if (push) begin
            expq.push_back(e); tagq.push_back(tag); n_pushed++;
        end
        alr = (f == 3'd1);
        send_half(alr, f, s, va);
        if (!only_a) send_half(~alr, f, s, vb);
    endtask

    task automatic idle_bits(input logic lr, input int n);
        for (int i = 0; i < n; i++) drive_bit(lr, '0);
    endtask

    task automatic set_cfg(input logic [2:0] f, input logic de, input logic dq);
        @(negedge clk);
        fmt_sel = f; div_en = de; div_quarter = dq;
        repeat (4) @(negedge clk);
    endtask

    task automatic measure_period(input int expv);
        logic prev;
        int n;
        do begin prev = bclk_out; @(negedge clk); end while (!(!prev && bclk_out));
        n = 0;
        do begin prev = bclk_out; @(negedge clk); n++; end while (!(!prev && bclk_out));
        check(n == expv, "R8", "bit clock period in clk cycles", 24'(n), 24'(expv));
    endtask

    task automatic run_group(input logic [2:0] f, input logic de, input logic dq,
                             input int s, input int nfr, input string tag);
        logic blr;
        set_cfg(f, de, dq);
        if (de) measure_period(dq ? 4 : 2);
        blr = (f == 3'd1) ? 1'b0 : 1'b1;
        idle_bits(blr, 4);
        for (int k = 0; k < nfr; k++) send_frame(f, s, k, tag, 1'b1, 1'b0);
        idle_bits(~blr, 4);
        repeat (8) @(negedge clk);
    endtask

    // monitor: pops one expected frame per strobe
    initial begin
        logic prev_v;
        prev_v = 1'b0;
        forever begin
            @(negedge clk);
            if (rst_n && samp_valid) begin
                n_valid++;
                check(!prev_v, "R6", "strobe width", 24'd2, 24'd1);
                if (expq.size() == 0) begin
                    check(1'b0, "R6/R9", "unexpected strobe", 24'd1, 24'd0);
                end else begin
                    frame_t e;
                    string t;
                    e = expq.pop_front();
                    t = tagq.pop_front();
                    for (int l = 0; l < LINES; l++) begin
                        check(samp_a[l] == e.a[l], t, $sformatf("line %0d A (R1)", l), samp_a[l], e.a[l]);
                        check(samp_b[l] == e.b[l], t, $sformatf("line %0d B (R1)", l), samp_b[l], e.b[l]);
                    end
                end
            end
            prev_v = rst_n && samp_valid;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            check(1'b0, "R6", "watchdog expired", 24'd0, 24'd1);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(samp_valid == 1'b0, "R10", "valid after reset", 24'(samp_valid), 24'd0);
        check(bclk_out == 1'b0, "R10", "bclk after reset", 24'(bclk_out), 24'd0);
        for (int l = 0; l < LINES; l++) begin
            check(samp_a[l] == '0, "R10", "A sample after reset", samp_a[l], 24'd0);
            check(samp_b[l] == '0, "R10", "B sample after reset", samp_b[l], 24'd0);
        end

        run_group(3'd0, 1'b0, 1'b0, 32, 3, "R2");
        run_group(3'd1, 1'b0, 1'b0, 32, 3, "R3");
        run_group(3'd2, 1'b0, 1'b0, 32, 3, "R4");
        run_group(3'd3, 1'b0, 1'b0, 32, 3, "R4");
        run_group(3'd4, 1'b0, 1'b0, 32, 3, "R4");
        run_group(3'd5, 1'b0, 1'b0, 32, 3, "R4");
        run_group(3'd0, 1'b0, 1'b1, 16, 2, "R2");
        check(bclk_out == 1'b0, "R8", "bclk while divider off", 24'(bclk_out), 24'd0);
        run_group(3'd1, 1'b0, 1'b1, 16, 2, "R3");
        run_group(3'd6, 1'b0, 1'b0, 32, 2, "R5");
        run_group(3'd7, 1'b0, 1'b0, 32, 2, "R5");
        run_group(3'd3, 1'b1, 1'b0, 32, 3, "R8");
        run_group(3'd1, 1'b1, 1'b1, 32, 3, "R8");
        run_group(3'd2, 1'b0, 1'b0, 16, 2, "R4");
        check(bclk_out == 1'b0, "R7", "bclk in external mode", 24'(bclk_out), 24'd0);

        // R9: format change between the A and B halves of a frame
        set_cfg(3'd0, 1'b0, 1'b0);
        idle_bits(1'b1, 4);
        send_frame(3'd0, 32, 1, "R9", 1'b1, 1'b0);
        send_frame(3'd0, 32, 2, "R9", 1'b0, 1'b1);
        set_cfg(3'd5, 1'b0, 1'b0);
        send_half(1'b1, 3'd5, 32, '1);
        send_frame(3'd5, 32, 3, "R9", 1'b1, 1'b0);
        idle_bits(1'b0, 4);
        repeat (8) @(negedge clk);
        check(n_valid == n_pushed, "R9", "strobes after mid-frame change",
              24'(n_valid), 24'(n_pushed));

        repeat (20) @(negedge clk);
        check(expq.size() == 0, "R6", "frames never delivered", 24'(expq.size()), 24'd0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

endmodule